// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

The block is a chain of identical 4-bit up-counter stages. Together they form one wide synchronous counter that can be preset in parallel. Each stage takes two count enables. The first, `enP`, goes to every stage in parallel. The second, `enT`, enters the first stage and is then passed along the chain through each stage's terminal-count output.

A stage advances only when both of its enables are high. Its terminal-count output is high when its second enable is high and its own count is all ones. That output enables the next stage on the same clock edge, so no stage is clocked from another stage's output.

An active-low master reset clears every stage. A parameter selects whether the reset acts at once or waits for the rising clock edge. An active-low load strobe copies the preset word into all stages on the rising edge. On each edge the order of priority is reset, then load, then count, then hold.

Top module: `cascade_counter`

## Requirements
- R1: While `mrN` is high and `loadN` is low, the rising edge loads `preset` into `count`, whatever the levels of `enP` and `enT`.
- R2: While `mrN` and `loadN` are high and both `enP` and `enT` are high, the rising edge adds one to the full `count` word, modulo 2^(STAGES*WIDTH).
- R3: While `mrN` and `loadN` are high and either `enP` or `enT` is low, `count` holds its value across the edge.
- R4: A stage that is enabled while it holds all ones wraps to zero. The carry goes into the next stage, so 4095 counts to 0 with the default three stages.
- R5: `tcOut` is high exactly when `enT` is high and every bit of `count` is one. It is combinational and follows `enT` within the same cycle.
- R6: While `mrN` is low, `count` is zero after the next rising edge, whatever the levels of `loadN`, `enP` and `enT`.
- R7: With ASYNC_RESET=1, a low `mrN` clears `count` without waiting for a clock edge.
- R8: With ASYNC_RESET=0, a low `mrN` changes nothing between clock edges. The clear takes effect on the next rising edge.
- R9: Across any mix of loads, resets and enable patterns, the cascaded `count` matches a plain integer counter that obeys R1 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change except the asynchronous reset happens on its rising edge |
| mrN | input | 1 | Master reset, active low |
| loadN | input | 1 | Parallel load strobe, active low |
| enP | input | 1 | Count enable sent to every stage in parallel |
| enT | input | 1 | Count enable that enters the first stage of the carry chain |
| preset | input | STAGES*WIDTH | Value loaded on a load edge |
| count | output | STAGES*WIDTH | Cascaded count; the first stage holds the least significant bits |
| tcOut | output | 1 | Terminal count of the last stage |

## Verification
The bench drives an asynchronous-reset copy and a synchronous-reset copy side by side with the same stimulus. It drops reset half a cycle before an edge. A design with the wrong reset style would clear too early in the synchronous copy, or wait for the edge in the asynchronous copy. Directed cases load 4095 and count through the wrap to zero. A stage that fails to pass its carry, or that wraps without carrying, would show a wrong upper nibble at that point. The bench also lowers `enT` while the count is all ones, which exposes a terminal count that ignores the enable. Reset is applied while a load is pending, and a load is applied with both enables high, to confirm the order of priority. Random traffic then compares every cycle against an integer model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic inc;
  } stepCtl_t;
endpackage

// File: rtl/stage_ctl.sv
module stage_ctl
  import cnt_pkg::*;
(
  input  logic     mrN,
  input  logic     loadN,
  input  logic     enP,
  input  logic     enT,
  output stepCtl_t ctl
);
  // Priority: clear, then load, then increment.
  always_comb begin
    ctl.clear = !mrN;
    ctl.load  = mrN && !loadN;
    ctl.inc   = mrN && loadN && enP && enT;
  end
endmodule

// File: rtl/stage_dp.sv
module stage_dp
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             arstN,
  input  stepCtl_t         ctl,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic             allOnes
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN)          q <= '0;
        else if (ctl.clear)  q <= '0;
        else if (ctl.load)   q <= preset;
        else if (ctl.inc)    q <= q + ONE;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (ctl.clear || !arstN) q <= '0;
        else if (ctl.load)       q <= preset;
        else if (ctl.inc)        q <= q + ONE;
      end
    end
  endgenerate

  assign allOnes = &q;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             mrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  stepCtl_t ctl;
  logic     allOnes;
  logic     arstN;

  assign arstN = ASYNC_RESET ? mrN : 1'b1;

  stage_ctl u_ctl (
    .mrN(mrN), .loadN(loadN), .enP(enP), .enT(enT), .ctl(ctl)
  );

  stage_dp #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_dp (
    .clk(clk), .arstN(arstN), .ctl(ctl), .preset(preset),
    .q(q), .allOnes(allOnes)
  );

  // Only the carry-chain enable gates the terminal count.
  assign tc = enT && allOnes;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES      = 3,
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1,
  localparam int TOTAL      = STAGES * WIDTH
) (
  input  logic             clk,
  input  logic             mrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [TOTAL-1:0] preset,
  output logic [TOTAL-1:0] count,
  output logic             tcOut
);
  logic [STAGES:0] tcChain;

  assign tcChain[0] = enT;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      cnt_stage #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_stage (
        .clk   (clk),
        .mrN   (mrN),
        .loadN (loadN),
        .enP   (enP),
        .enT   (tcChain[k]),
        .preset(preset[k*WIDTH +: WIDTH]),
        .q     (count[k*WIDTH +: WIDTH]),
        .tc    (tcChain[k+1])
      );
    end
  endgenerate

  assign tcOut = tcChain[STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int TOTAL = 12
) (
  input logic             clk,
  input logic             mrN,
  input logic             loadN,
  input logic             enP,
  input logic             enT,
  input logic [TOTAL-1:0] preset,
  input logic [TOTAL-1:0] count,
  input logic             tcOut
);
  p_load_r1: assert property (@(posedge clk) disable iff (!mrN)
    !loadN |=> count == $past(preset));

  p_count_r2: assert property (@(posedge clk) disable iff (!mrN)
    (loadN && enP && enT) |=> count == TOTAL'($past(count) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!mrN)
    (loadN && !(enP && enT)) |=> $stable(count));

  p_tc_r5: assert property (@(posedge clk) disable iff (!mrN)
    tcOut |-> (enT && (&count)));

  p_reset_r6: assert property (@(posedge clk)
    (mrN === 1'b0) |=> count == '0);
endmodule

bind cascade_counter cascade_counter_chk #(.TOTAL(TOTAL)) u_chk (
  .clk(clk), .mrN(mrN), .loadN(loadN), .enP(enP), .enT(enT),
  .preset(preset), .count(count), .tcOut(tcOut)
);

// File: tb/sim_cascade_counter.sv
`timescale 1ns/1ps
module sim_cascade_counter;
  localparam int W = 12;

  logic clk = 1'b0;
  logic mrN = 1'b0, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] countA, countS;
  logic tcA, tcS;
  int checks = 0, errors = 0;
  logic [W-1:0] refA = '0, refS = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_counter #(.ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .mrN(mrN), .loadN(loadN), .enP(enP), .enT(enT),
    .preset(preset), .count(countA), .tcOut(tcA)
  );
  cascade_counter #(.ASYNC_RESET(1'b0)) u1 (
    .clk(clk), .mrN(mrN), .loadN(loadN), .enP(enP), .enT(enT),
    .preset(preset), .count(countS), .tcOut(tcS)
  );

  function automatic logic [W-1:0] nxt(logic [W-1:0] cur, logic m, logic l,
                                      logic p, logic t, logic [W-1:0] pr);
    if (!m)         return '0;
    else if (!l)    return pr;
    else if (p && t) return cur + 1'b1;
    else            return cur;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req, logic m, logic l, logic p, logic t,
                      logic [W-1:0] pr);
    @(negedge clk);
    mrN = m; loadN = l; enP = p; enT = t; preset = pr;
    @(posedge clk);
    refA = nxt(refA, m, l, p, t, pr);
    refS = nxt(refS, m, l, p, t, pr);
    #1;
    chk({req, " R9 countA"}, countA, refA);
    chk({req, " R9 countS"}, countS, refS);
    chk({req, " R5 tcA"}, W'(tcA), W'(t && (&refA)));
    chk({req, " R5 tcS"}, W'(tcS), W'(t && (&refS)));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // Reset state (R6)
    step("R6 reset", 1'b0, 1'b0, 1'b1, 1'b1, 12'hABC);
    chk("R6 reset zero", countA, '0);
    // R1 load ignores enables
    step("R1 load", 1'b1, 1'b0, 1'b1, 1'b1, 12'd4093);
    chk("R1 load value", countS, 12'd4093);
    step("R1 load en low", 1'b1, 1'b0, 1'b0, 1'b0, 12'd4094);
    // R2 count, reach max
    step("R2 count", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R2 at max", countA, 12'd4095);
    // R5 enT low at max: tc low, hold
    step("R3 hold enT low", 1'b1, 1'b1, 1'b1, 1'b0, '0);
    chk("R5 tc gated by enT", W'(tcA), '0);
    // R3 hold with enP low, tc still high
    step("R3 hold enP low", 1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk("R5 tc with enP low", W'(tcS), W'(1'b1));
    // R4 wrap
    step("R4 wrap", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R4 wrap zero", countA, '0);
    // R4 inner carry: 0x0FF -> 0x100
    step("R4 load", 1'b1, 1'b0, 1'b1, 1'b1, 12'h0FF);
    step("R4 carry", 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R4 carry stage", countS, 12'h100);
    // R7/R8: reset mid-cycle
    step("R7 preload", 1'b1, 1'b0, 1'b0, 1'b0, 12'h5A5);
    @(negedge clk);
    mrN = 1'b0; loadN = 1'b0; enP = 1'b1; enT = 1'b1;
    #1;
    chk("R7 async clear before edge", countA, '0);
    chk("R8 sync holds before edge", countS, 12'h5A5);
    @(posedge clk);
    refA = '0; refS = '0;
    #1;
    chk("R8 sync clear at edge", countS, '0);
    chk("R6 reset over load", countA, '0);
    // R9 random traffic
    for (int i = 0; i < 2000; i++) begin
      logic m, l, p, t;
      logic [W-1:0] pr;
      m = ($urandom % 40) != 0;
      l = ($urandom % 16) != 0;
      p = ($urandom % 8) != 0;
      t = ($urandom % 8) != 0;
      pr = ($urandom % 4 == 0) ? W'(4090 + $urandom % 6) : W'($urandom);
      step("R9 random", m, l, p, t, pr);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule